// File: doc/BRIEF.md
# Configuration Register Slave for a Clock Generator

This block is a two-wire serial bus slave that holds the configuration bytes of a system clock generator. It accepts only whole-block transfers. In a write, the two bytes after the address byte are a command byte and a length byte. The slave acknowledges both and throws their values away. Every later byte lands in the next register, starting from register 0, until the master ends the transfer. In a read, the slave first sends a length byte, then the registers in ascending order. Neither direction has a register pointer.

During reset the block samples five strap pins: four frequency-select straps and a mode strap. It keeps them inverted in a read-only field. A source bit in register 0 chooses whether the frequency-select output follows the straps or register fields. The remaining registers drive the per-output enables, the spread-spectrum control and the global tristate control. SCL and SDA are oversampled by the system clock through two-flop synchronizers. The slave pulls SDA low through `sda_oe_o`.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read). Any other address byte gets no acknowledge and changes no register.
- R2: In a write, the first two bytes after the address are acknowledged and leave every register unchanged.
- R3: Later write bytes go to registers 0, 1, 2 … in order. A stop after any complete byte leaves the registers not yet reached unchanged.
- R4: Write bytes after register 5 are acknowledged and discarded.
- R5: A read returns the value 6, then registers 0 to 5, then 0xFF for any further byte. A master not-acknowledge ends the transfer.
- R6: After reset, register 0 is 0x00, registers 1 to 4 are 0xFF, and bits 7:5 of register 5 are 111.
- R7: Bits 4:0 of register 5 hold the inverted strap pins as seen during reset (bit n = ~strap_i[n]). Writes do not change them, and strap changes after reset do not change them.
- R8: If register 0 bit 3 is 0, freq_sel_o = {0, strap[3:0]} from the straps sampled during reset. If it is 1, freq_sel_o = {reg0[2], reg0[7:4]}.
- R9: spread_en_o is register 0 bit 1. tristate_o is register 0 bit 0. out_en_o[8k+7:8k] is register k+1 for k = 0..3 (1 = enabled). aux_o is register 5 bits 7:5. mode_o is the mode strap (strap_i[4]) sampled during reset.
- R10: The slave changes SDA only while SCL is low. A repeated start aborts the current transfer and begins a new one at its address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset; straps are sampled while it is low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 5 | Strap pins: [3:0] frequency select, [4] mode |
| freq_sel_o | output | 5 | Active frequency-select code |
| spread_en_o | output | 1 | Spread-spectrum enable |
| tristate_o | output | 1 | Puts all clock outputs in high impedance |
| mode_o | output | 1 | Sampled mode strap |
| out_en_o | output | 32 | Per-output enables from registers 1 to 4 |
| aux_o | output | 3 | Writable upper bits of register 5 |

## Verification
The assertions check on every cycle that SDA only moves while the synchronized SCL is low, and that an idle slave never holds the line. They also check that the strap latch stays frozen after reset, that at most one register is written per byte, and that the byte counter saturates. Only the bench scenarios can show the values themselves. These are the acknowledge pattern for good and bad addresses, the header bytes being discarded, the register contents after a partial write and after an overlong write, and the exact order of a block read. The same applies to the strap-versus-register selection of the frequency code.

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NREG = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic [4:0]  strap_i,
  output logic [4:0]  freq_sel_o,
  output logic        spread_en_o,
  output logic        tristate_o,
  output logic        mode_o,
  output logic [8*(NREG-2)-1:0] out_en_o,
  output logic [2:0]  aux_o
);
  localparam int NSTRAP = 5;
  localparam int AW = 8 - NSTRAP;
  localparam int CW = $clog2(NREG + 3);
  localparam logic [CW-1:0] SAT = CW'(NREG + 2);

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} st_t;

  st_t st;
  logic [2:0] scl_p, sda_p;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic rw, addr_ph, mack;
  logic [CW-1:0] bcnt;
  logic [7:0] regs [NREG-1];
  logic [AW-1:0] aux_q;
  logic [NSTRAP-1:0] strap_q;
  logic [7:0] tx_next;
  logic [NREG-1:0] wr_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  wire scl_rise = scl_p[1] & ~scl_p[2];
  wire scl_fall = ~scl_p[1] & scl_p[2];
  wire start_c  = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire stop_c   = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
  wire byte_done = (st == ST_RX) && scl_fall && (cnt == 4'd8);
  wire wr_pulse  = byte_done && !addr_ph;
  wire do_load   = scl_fall && (((st == ST_ACK) && rw) || ((st == ST_MACK) && !mack));

  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= ~strap_i;
  end

  always_comb begin
    tx_next = 8'hFF;
    if (bcnt == '0) tx_next = 8'(NREG);
    for (int i = 0; i < NREG - 1; i++)
      if (bcnt == CW'(i + 1)) tx_next = regs[i];
    if (bcnt == CW'(NREG)) tx_next = {aux_q, strap_q};
  end

  always_comb begin
    for (int i = 0; i < NREG; i++)
      wr_sel[i] = wr_pulse && (bcnt == CW'(i + 2));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      cnt <= '0;
      sh <= '0;
      rw <= 1'b0;
      addr_ph <= 1'b0;
      mack <= 1'b0;
      bcnt <= '0;
      sda_oe_o <= 1'b0;
    end else if (start_c) begin
      st <= ST_RX;
      cnt <= '0;
      addr_ph <= 1'b1;
      bcnt <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_c) begin
      st <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else if (do_load) begin
      sh <= tx_next;
      sda_oe_o <= ~tx_next[7];
      cnt <= 4'd1;
      st <= ST_TX;
      if (bcnt != SAT) bcnt <= bcnt + 1'b1;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise && cnt != 4'd8) begin
            sh <= {sh[6:0], sda_p[1]};
            cnt <= cnt + 1'b1;
          end else if (byte_done) begin
            addr_ph <= 1'b0;
            if (addr_ph) begin
              if (sh[7:1] == DEV_ADDR) begin
                sda_oe_o <= 1'b1;
                rw <= sh[0];
                st <= ST_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              sda_oe_o <= 1'b1;
              st <= ST_ACK;
              if (bcnt != SAT) bcnt <= bcnt + 1'b1;
            end
          end
        end
        ST_ACK: if (scl_fall) begin
          sda_oe_o <= 1'b0;
          cnt <= '0;
          st <= ST_RX;
        end
        ST_TX: if (scl_fall) begin
          if (cnt == 4'd8) begin
            sda_oe_o <= 1'b0;
            st <= ST_MACK;
          end else begin
            sda_oe_o <= ~sh[6];
            sh <= {sh[6:0], 1'b0};
            cnt <= cnt + 1'b1;
          end
        end
        ST_MACK: begin
          if (scl_rise) mack <= sda_p[1];
          else if (scl_fall) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG - 1; i++) regs[i] <= (i == 0) ? 8'h00 : 8'hFF;
      aux_q <= '1;
    end else begin
      for (int i = 0; i < NREG - 1; i++)
        if (wr_sel[i]) regs[i] <= sh;
      if (wr_sel[NREG-1]) aux_q <= sh[7:NSTRAP];
    end
  end

  assign freq_sel_o  = regs[0][3] ? {regs[0][2], regs[0][7:4]} : {1'b0, ~strap_q[3:0]};
  assign spread_en_o = regs[0][1];
  assign tristate_o  = regs[0][0];
  assign mode_o      = ~strap_q[4];
  assign aux_o       = aux_q;

  always_comb begin
    for (int i = 1; i < NREG - 1; i++) out_en_o[8*(i-1) +: 8] = regs[i];
  end

  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> (!$past(scl_p[1]) || !sda_oe_o));

  a_r1_idle_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe_o);

  a_r3_one_reg_per_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  a_r4_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= SAT);

  a_r7_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(strap_q));

  a_r5_drive_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o && st == ST_TX) |-> rw);
endmodule

// File: tb/i2c_cfg_slave_bench.sv
module i2c_cfg_slave_bench;
  localparam int Q = 10;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, scl, m_low, sda_oe;
  logic [4:0] strap, freq_sel;
  logic spread_en, tristate, mode;
  logic [31:0] out_en;
  logic [2:0] aux;
  logic sda_line;
  assign sda_line = ~(m_low | sda_oe);

  i2c_cfg_slave u_i2c_cfg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(strap), .freq_sel_o(freq_sel), .spread_en_o(spread_en),
    .tristate_o(tristate), .mode_o(mode), .out_en_o(out_en), .aux_o(aux));

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 0; q(Q); scl = 1; q(Q); m_low = 1; q(Q); scl = 0; q(Q);
  endtask

  task automatic bus_stop();
    m_low = 1; q(Q); scl = 1; q(Q); m_low = 0; q(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; q(Q); scl = 1; q(2*Q); scl = 0; q(Q);
    end
    m_low = 0; q(Q); scl = 1; q(Q); ack = ~sda_line; q(Q); scl = 0; q(Q);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    m_low = 0;
    for (int i = 7; i >= 0; i--) begin
      q(Q); scl = 1; q(Q); b[i] = sda_line; q(Q); scl = 0;
    end
    q(Q); m_low = ~nack; q(Q); scl = 1; q(2*Q); scl = 0; q(Q); m_low = 0;
  endtask

  task automatic put_exp(input logic [7:0] b);
    exp_q.push_back(b);
  endtask

  task automatic read_all(input string req);
    bit ack;
    logic [7:0] b;
    int n;
    n = exp_q.size();
    bus_start();
    send_byte(8'hD3, ack);
    check(ack, {req, " R1 read address ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, b);
      begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(b === e, {req, " R5 read byte"}, b, e);
      end
    end
    bus_stop();
  endtask

  task automatic write_block(input logic [7:0] data [], input string req);
    bit ack;
    bus_start();
    send_byte(8'hD2, ack);
    check(ack, {req, " R1 write address ack"}, ack, 1);
    send_byte(8'h55, ack);
    check(ack, {req, " R2 command byte ack"}, ack, 1);
    send_byte(8'h77, ack);
    check(ack, {req, " R2 length byte ack"}, ack, 1);
    foreach (data[i]) begin
      send_byte(data[i], ack);
      check(ack, {req, " R3/R4 data byte ack"}, ack, 1);
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] wd [];
    rst_n = 0; scl = 1; m_low = 0; strap = 5'b10110;
    q(5);
    rst_n = 1;
    q(5);
    strap = 5'b01001;
    q(5);

    check(out_en === 32'hFFFF_FFFF, "R6 reset enables", out_en, 32'hFFFF_FFFF);
    check({spread_en, tristate} === 2'b00, "R6/R9 reset controls", {spread_en, tristate}, 0);
    check(aux === 3'b111, "R6 reset aux", aux, 3'b111);
    check(freq_sel === 5'b00110, "R8 strap source", freq_sel, 5'b00110);
    check(mode === 1'b1, "R9 mode strap", mode, 1);

    put_exp(8'd6); put_exp(8'h00);
    for (int i = 0; i < 4; i++) put_exp(8'hFF);
    put_exp(8'hE9);
    read_all("R6/R7 reset readback");

    bus_start();
    send_byte(8'hA0, ack);
    check(!ack, "R1 foreign address nack", ack, 0);
    send_byte(8'h0F, ack);
    check(!ack, "R1 no ack after foreign address", ack, 0);
    bus_stop();
    check(out_en === 32'hFFFF_FFFF && !spread_en, "R1 foreign write ignored", out_en, 32'hFFFF_FFFF);

    wd = new[2];
    wd[0] = 8'hBA; wd[1] = 8'h3C;
    write_block(wd, "partial");
    check(spread_en === 1'b1 && tristate === 1'b0, "R9 spread from reg0", {spread_en, tristate}, 2'b10);
    check(freq_sel === 5'b01011, "R8 register source", freq_sel, 5'b01011);
    check(out_en === 32'hFFFF_FF3C, "R3 partial write", out_en, 32'hFFFF_FF3C);

    put_exp(8'd6); put_exp(8'hBA); put_exp(8'h3C);
    put_exp(8'hFF); put_exp(8'hFF); put_exp(8'hFF); put_exp(8'hE9);
    read_all("R2/R3 after partial");

    wd = new[8];
    wd[0] = 8'h01; wd[1] = 8'h11; wd[2] = 8'h22; wd[3] = 8'h33;
    wd[4] = 8'h44; wd[5] = 8'h5F; wd[6] = 8'h99; wd[7] = 8'h98;
    write_block(wd, "overlong");
    check(tristate === 1'b1, "R9 tristate", tristate, 1);
    check(out_en === 32'h4433_2211, "R4 enables after overlong", out_en, 32'h4433_2211);
    check(aux === 3'b010, "R9 aux bits", aux, 3'b010);
    check(freq_sel === 5'b00110, "R7 strap held after reset", freq_sel, 5'b00110);

    put_exp(8'd6); put_exp(8'h01); put_exp(8'h11); put_exp(8'h22);
    put_exp(8'h33); put_exp(8'h44); put_exp(8'h49); put_exp(8'hFF); put_exp(8'hFF);
    read_all("R4/R7 full readback");

    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h00, ack);
    check(ack, "R10 header before restart", ack, 1);
    put_exp(8'd6); put_exp(8'h01);
    read_all("R10 repeated start");
    check(out_en === 32'h4433_2211, "R10 aborted write changed nothing", out_en, 32'h4433_2211);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule